// File: doc/BRIEF.md
# Display Frame Base Shadow and Update Interrupt

This unit keeps the memory base address of the frame a display controller scans out. Software writes a new base into a shadow register over a small register bus. The value the pixel fetcher uses does not change at that moment. It changes at the next frame-start pulse, when the shadow is copied into the active base. That same hand-over raises a "base taken" interrupt, so software can flip between buffers without tearing and knows when the old buffer is free.

Interrupt state has the usual parts: a raw status bit, an enable bit, a masked view (raw AND enable) that software polls, and a write-one-to-clear register. The interrupt line is the OR of the masked bits, and it serves as the vertical-blank indication. The register bus is a single-cycle write strobe with address and data. Read data is a combinational function of the address.

Register word indices, which the bench relies on: 0 shadow base (read/write), 1 active base (read-only), 2 interrupt enable (bit 0), 3 raw status (bit 0), 4 masked status (bit 0), 5 interrupt clear (write-only, bit 0). Indices 6 and 7 are unmapped.

Top module: `fbu_frame_base`

## Requirements
- R1: After reset, the shadow base, active base, enable bit and raw status all read zero, and `irq` is low.
- R2: A write to index 0 stores the write data with bits [1:0] forced to zero. Index 0 reads back that value. The active base does not change until a frame start.
- R3: A frame-start pulse while a written base is pending copies the shadow into `base_addr` at that clock edge, clears the pending state and sets raw status bit 0 at the same edge.
- R4: A frame-start pulse with no base write pending leaves `base_addr` and the raw status unchanged.
- R5: When a base write and a frame-start pulse fall in the same cycle, nothing is loaded. The newly written value stays pending and is loaded at the following frame start.
- R6: Writing 1 in bit 0 of index 2 enables the source, and writing 0 disables it. Index 4 reads raw AND enable, and `irq` is the OR of the masked bits.
- R7: Writing index 5 with bit 0 set clears raw status bit 0. Writing it with bit 0 clear leaves the status unchanged.
- R8: If a clear and a new status set fall in the same cycle, the status ends up set.
- R9: Several base writes before one frame start result in only the last value being loaded.
- R10: Index 5 and the unmapped indices read zero. Writes to indices 1, 3 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| base_addr | output | DATA_W | Active frame base given to the pixel fetcher |
| irq | output | 1 | Interrupt, OR of the masked status bits |

## Verification
The cases that are hardest to reach from the ports are the collisions: a base write in the very cycle of a frame start, and a clear write in the very cycle the status gets set. The bench drives every input in its own cycle slot. This lets it put the strobe and the frame-start pulse on the same edge on purpose. A behavioural model then predicts the active base, the status and every read value cycle by cycle, including the edge after each collision.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    IDX_SHADOW = 3'd0,
    IDX_ACTIVE = 3'd1,
    IDX_IEN    = 3'd2,
    IDX_RAW    = 3'd3,
    IDX_MASKED = 3'd4,
    IDX_CLEAR  = 3'd5
  } fbu_idx_e;
endpackage

// File: rtl/fbu_rst_sync.sv
module fbu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fbu_regif.sv
module fbu_regif
  import fbu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] shadow,
  input  logic [DATA_W-1:0] active,
  input  logic              ien,
  input  logic              raw,
  output logic              wr_shadow,
  output logic              wr_ien,
  output logic              wr_clear,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    wr_shadow = wr && (addr == IDX_SHADOW);
    wr_ien    = wr && (addr == IDX_IEN);
    wr_clear  = wr && (addr == IDX_CLEAR);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      IDX_SHADOW: rdata = shadow;
      IDX_ACTIVE: rdata = active;
      IDX_IEN:    rdata[0] = ien;
      IDX_RAW:    rdata[0] = raw;
      IDX_MASKED: rdata[0] = raw & ien;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/fbu_base_shadow.sv
module fbu_base_shadow #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_shadow,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_start,
  output logic [DATA_W-1:0] shadow,
  output logic [DATA_W-1:0] active,
  output logic              pending,
  output logic              loaded
);
  localparam logic [DATA_W-1:0] ALIGN_MASK =
    {{(DATA_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [DATA_W-1:0] shadow_q, shadow_d, active_q, active_d;
  logic              pend_q, pend_d;
  logic              shadow_en, active_en, pend_en;

  always_comb begin
    loaded    = frame_start && pend_q && !wr_shadow;
    shadow_en = wr_shadow;
    active_en = loaded;
    pend_en   = wr_shadow || loaded;
    shadow_d  = wdata & ALIGN_MASK;
    active_d  = shadow_q;
    pend_d    = wr_shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (active_en) active_q <= active_d;
      if (pend_en)   pend_q   <= pend_d;
    end
  end

  assign shadow  = shadow_q;
  assign active  = active_q;
  assign pending = pend_q;

  assert_write_pends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_shadow |=> pend_q);

  assert_collision_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shadow && frame_start) |=> $stable(active_q));

  assert_idle_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !pend_q) |=> $stable(active_q));
endmodule

// File: rtl/fbu_irq_ctrl.sv
module fbu_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_ien,
  input  logic wr_clear,
  input  logic wbit,
  output logic ien,
  output logic raw,
  output logic irq
);
  logic ien_q, ien_d, ien_en;
  logic raw_q, raw_d, raw_en;
  logic clr_hit;

  always_comb begin
    clr_hit = wr_clear && wbit;
    ien_en  = wr_ien;
    ien_d   = wbit;
    raw_en  = set_evt || clr_hit;
    raw_d   = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      raw_q <= 1'b0;
    end else begin
      if (ien_en) ien_q <= ien_d;
      if (raw_en) raw_q <= raw_d;
    end
  end

  assign ien = ien_q;
  assign raw = raw_q;
  assign irq = raw_q & ien_q;

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> raw_q);

  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_evt) |=> !raw_q);

  assert_zero_clear_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit && !set_evt) |=> $stable(raw_q));
endmodule

// File: rtl/fbu_frame_base.sv
module fbu_frame_base
  import fbu_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ALIGN_BITS  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] base_addr,
  output logic              irq
);
  logic              rst_n_i;
  logic              wr_shadow, wr_ien, wr_clear;
  logic [DATA_W-1:0] shadow, active;
  logic              pending, loaded, ien, raw;

  fbu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  fbu_regif #(.DATA_W(DATA_W)) u_regif (
    .addr      (reg_addr),
    .wr        (reg_wr),
    .shadow    (shadow),
    .active    (active),
    .ien       (ien),
    .raw       (raw),
    .wr_shadow (wr_shadow),
    .wr_ien    (wr_ien),
    .wr_clear  (wr_clear),
    .rdata     (reg_rdata)
  );

  fbu_base_shadow #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .wr_shadow   (wr_shadow),
    .wdata       (reg_wdata),
    .frame_start (frame_start),
    .shadow      (shadow),
    .active      (active),
    .pending     (pending),
    .loaded      (loaded)
  );

  fbu_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .set_evt  (loaded),
    .wr_ien   (wr_ien),
    .wr_clear (wr_clear),
    .wbit     (reg_wdata[0]),
    .ien      (ien),
    .raw      (raw),
    .irq      (irq)
  );

  assign base_addr = active;

  assert_load_raises_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frame_start && pending && !wr_shadow) |=> (raw && base_addr == $past(shadow)));

  assert_aligned_read_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (reg_addr == IDX_SHADOW) |-> (reg_rdata[ALIGN_BITS-1:0] == '0));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    !ien |-> !irq);
endmodule

// File: tb/fbu_frame_base_test.sv
`timescale 1ns/1ps
module fbu_frame_base_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_wr;
  logic [31:0] reg_rdata;
  logic [31:0] base_addr;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_shadow = 0, m_active = 0;
  bit m_pend = 0, m_en = 0, m_raw = 0;

  always #4 clk = ~clk;

  fbu_frame_base uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .base_addr(base_addr), .irq(irq)
  );

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_shadow;
      3'd1: return m_active;
      3'd2: return {31'd0, m_en};
      3'd3: return {31'd0, m_raw};
      3'd4: return {31'd0, m_raw & m_en};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit fs, input bit wr, input logic [2:0] a,
                     input logic [31:0] d, input string req);
    bit ld, clr;
    logic [31:0] old_sh;
    @(negedge clk);
    frame_start = fs; reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    chk(req, "rdata", reg_rdata, mread(a));
    chk(req, "base_addr", base_addr, m_active);
    chk(req, "irq", {31'd0, irq}, {31'd0, m_raw & m_en});
    @(posedge clk);
    old_sh = m_shadow;
    ld  = fs && m_pend && !(wr && a == 3'd0);
    clr = wr && a == 3'd5 && d[0];
    if (wr && a == 3'd0) begin m_shadow = d & 32'hFFFF_FFFC; m_pend = 1; end
    else if (ld) m_pend = 0;
    if (ld) m_active = old_sh;
    if (ld) m_raw = 1; else if (clr) m_raw = 0;
    if (wr && a == 3'd2) m_en = d[0];
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    cyc(0, 0, a, 32'd0, req);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; frame_start = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state over all indices, R10: unmapped reads zero
    for (int i = 0; i < 5; i++) rd(3'(i), "R1");
    for (int i = 5; i < 8; i++) rd(3'(i), "R10");
    // R2: aligned store, active untouched
    cyc(0, 1, 3'd0, 32'h1000_0003, "R2");
    rd(3'd0, "R2"); rd(3'd1, "R2");
    // R3: frame start loads and raises raw; irq stays low while disabled (R6)
    cyc(1, 0, 3'd3, 0, "R3");
    rd(3'd3, "R3"); rd(3'd1, "R3"); rd(3'd4, "R6");
    // R6: enable then irq
    cyc(0, 1, 3'd2, 32'h1, "R6");
    rd(3'd4, "R6"); rd(3'd2, "R6");
    // R7: zero-clear keeps, one-clear clears
    cyc(0, 1, 3'd5, 32'h0, "R7"); rd(3'd3, "R7");
    cyc(0, 1, 3'd5, 32'h1, "R7"); rd(3'd3, "R7"); rd(3'd5, "R10");
    // R4: frame start with nothing pending
    cyc(1, 0, 3'd1, 0, "R4"); rd(3'd3, "R4"); rd(3'd1, "R4");
    // R5: collision keeps the new value pending
    cyc(1, 1, 3'd0, 32'h2000_0010, "R5");
    rd(3'd1, "R5"); rd(3'd3, "R5");
    cyc(1, 0, 3'd1, 0, "R5"); rd(3'd1, "R5"); rd(3'd3, "R5");
    cyc(0, 1, 3'd5, 32'h1, "R7");
    // R9: last of several writes wins
    cyc(0, 1, 3'd0, 32'h3000_0000, "R9");
    cyc(0, 1, 3'd0, 32'h3400_0101, "R9");
    cyc(0, 1, 3'd0, 32'h3800_0fff, "R9");
    rd(3'd1, "R9");
    // R8: clear write on the same edge as the set
    cyc(1, 1, 3'd5, 32'h1, "R8");
    rd(3'd3, "R8"); rd(3'd1, "R9"); rd(3'd4, "R8");
    // R10: writes to read-only indices change nothing
    cyc(0, 1, 3'd1, 32'hDEAD_BEEF, "R10");
    cyc(0, 1, 3'd3, 32'h0, "R10");
    cyc(0, 1, 3'd4, 32'h0, "R10");
    rd(3'd1, "R10"); rd(3'd3, "R10"); rd(3'd4, "R10");
    // R6: disable masks irq while raw stays set
    cyc(0, 1, 3'd2, 32'h0, "R6");
    rd(3'd3, "R6"); rd(3'd4, "R6");
    for (int i = 0; i < 4; i++) rd(3'(i), "R6");
    done = 1;
    summary();
    $finish;
  end
endmodule